// File: doc/BRIEF.md
# Seat Belt Reminder Controller

This block warns a driver who switches the ignition on and leaves the seat belt unbuckled. It is built from two synchronous parts that step on the same clock edge. One is a three-state control machine (idle, waiting, alarming). The other is a seconds counter that advances on an external one-second tick. The whole block's state is the pair of machine state and counter value.

When the ignition comes on, the machine starts the counter and waits. If the belt is fastened or the ignition goes off before the fifth tick, the machine goes back to idle quietly. On the fifth tick the machine raises the alarm. The alarm ends when the belt is fastened, when the ignition goes off, or at the tenth tick, whichever comes first. So the alarm sounds for at most five ticks. The start, alarm-on and alarm-off outputs are single-cycle pulses produced in the same cycle as the event that causes them. A level output stays high for as long as the alarm lasts.

All inputs are single-cycle strobes from logic that is already clean, and the one-second tick comes from outside the block.

Top module: `belt_reminder_top`

## Requirements
- R1: While reset is high and in the first cycle after it, all four outputs are low and the machine is idle.
- R2: In idle, a key-on strobe drives `timer_start` high in that same cycle, and the machine is waiting from the next cycle. In any other state, key-on does nothing.
- R3: While waiting, a key-off or belt strobe returns the machine to idle. No `alarm_on` pulse is produced, and `alarm_active` stays low.
- R4: While waiting, the fifth tick counted after the start pulse drives `alarm_on` high in that cycle, and `alarm_active` is high from the next cycle.
- R5: While alarming, a key-off strobe, a belt strobe or the tenth counted tick drives `alarm_off` high in that cycle, and `alarm_active` is low from the next cycle.
- R6: In a cycle where no condition listed in R2 to R5 holds, the state is unchanged and all three pulse outputs are low.
- R7: The start pulse resets the count to 0, and a tick in the same cycle as the start pulse is not counted. After the tenth counted tick the counter goes idle, and further ticks raise no event until the next start.
- R8: While waiting, if key-off and the fifth tick arrive in the same cycle, key-off wins. The machine goes idle with no `alarm_on` pulse.
- R9: `alarm_active` is high exactly in the cycles in which the machine is alarming. It rises only in the cycle after an `alarm_on` pulse and falls only in the cycle after an `alarm_off` pulse.
- R10: At most five ticks are seen while `alarm_active` is high, counting the tick that ends the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_on | input | 1 | Ignition-on strobe |
| key_off | input | 1 | Ignition-off strobe |
| belt_on | input | 1 | Belt-fastened strobe |
| sec_tick | input | 1 | One-second tick pulse |
| timer_start | output | 1 | Pulse: counter restarted |
| alarm_on | output | 1 | Pulse: alarm begins |
| alarm_off | output | 1 | Pulse: alarm ends |
| alarm_active | output | 1 | Level, high while alarming |

## Verification
The hardest cases to reach from the ports are those where a tick meets another event in one cycle. Examples are a tick in the same cycle as key-on, key-off together with the fifth tick, and belt together with the tenth tick. The alarm must also run the full five ticks with no interruption, which random strobes rarely allow. Directed sequences count the ticks exactly to reach these cycles. Random traffic with sparse key and belt strobes and denser ticks covers the rest against a reference model of the two machines in the bench.

// File: rtl/belt_pkg.sv
package belt_pkg;

    localparam int unsigned FIRST_TICKS_DEF  = 5;
    localparam int unsigned SECOND_TICKS_DEF = 10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ALARM = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic key_on;
        logic key_off;
        logic belt;
        logic ev_first;
        logic ev_second;
    } ctrl_events_t;

    typedef struct packed {
        logic start;
        logic alarm_on;
        logic alarm_off;
    } ctrl_pulses_t;

    typedef struct packed {
        ctrl_state_e  next;
        ctrl_pulses_t pulses;
    } ctrl_reaction_t;

    // One reaction of the control machine: next state and emitted pulses.
    function automatic ctrl_reaction_t ctrl_react(ctrl_state_e cur, ctrl_events_t ev);
        ctrl_reaction_t r;
        r.next   = cur;
        r.pulses = '0;
        unique case (cur)
            ST_IDLE: begin
                if (ev.key_on) begin
                    r.next         = ST_WAIT;
                    r.pulses.start = 1'b1;
                end
            end
            ST_WAIT: begin
                // leaving quietly takes precedence over the first timer event
                if (ev.key_off || ev.belt) begin
                    r.next = ST_IDLE;
                end else if (ev.ev_first) begin
                    r.next            = ST_ALARM;
                    r.pulses.alarm_on = 1'b1;
                end
            end
            ST_ALARM: begin
                if (ev.key_off || ev.belt || ev.ev_second) begin
                    r.next             = ST_IDLE;
                    r.pulses.alarm_off = 1'b1;
                end
            end
            default: begin
                r.next = ST_IDLE;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/belt_tick_timer.sv
module belt_tick_timer
    import belt_pkg::*;
#(
    parameter int unsigned FIRST_TICKS  = FIRST_TICKS_DEF,
    parameter int unsigned SECOND_TICKS = SECOND_TICKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic tick,
    output logic ev_first,
    output logic ev_second
);
    localparam int unsigned CNT_W = $clog2(SECOND_TICKS + 1);
    localparam logic [CNT_W-1:0] FIRST_LAST  = CNT_W'(FIRST_TICKS - 1);
    localparam logic [CNT_W-1:0] SECOND_LAST = CNT_W'(SECOND_TICKS - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t cur_q, nxt;
    logic         counting;

    assign counting  = cur_q.run && tick && !start;
    assign ev_first  = counting && (cur_q.cnt == FIRST_LAST);
    assign ev_second = counting && (cur_q.cnt == SECOND_LAST);

    always_comb begin
        nxt = cur_q;
        if (start) begin
            nxt.run = 1'b1;
            nxt.cnt = '0;
        end else if (counting) begin
            if (ev_second) begin
                nxt.run = 1'b0;
                nxt.cnt = '0;
            end else begin
                nxt.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt;
        end
    end
endmodule

// File: rtl/belt_ctrl_fsm.sv
module belt_ctrl_fsm
    import belt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  ctrl_events_t ev,
    output ctrl_pulses_t pulses,
    output logic         alarming
);
    ctrl_state_e    state_q;
    ctrl_reaction_t react;

    always_comb begin
        react = ctrl_react(state_q, ev);
    end

    assign pulses   = react.pulses;
    assign alarming = (state_q == ST_ALARM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= react.next;
        end
    end
endmodule

// File: rtl/belt_reminder_top.sv
module belt_reminder_top
    import belt_pkg::*;
#(
    parameter int unsigned FIRST_TICKS  = FIRST_TICKS_DEF,
    parameter int unsigned SECOND_TICKS = SECOND_TICKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic key_on,
    input  logic key_off,
    input  logic belt_on,
    input  logic sec_tick,
    output logic timer_start,
    output logic alarm_on,
    output logic alarm_off,
    output logic alarm_active
);
    ctrl_events_t ev;
    ctrl_pulses_t pulses;
    logic         ev_first;
    logic         ev_second;

    always_comb begin
        ev.key_on    = key_on;
        ev.key_off   = key_off;
        ev.belt      = belt_on;
        ev.ev_first  = ev_first;
        ev.ev_second = ev_second;
    end

    belt_tick_timer #(
        .FIRST_TICKS  (FIRST_TICKS),
        .SECOND_TICKS (SECOND_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (pulses.start),
        .tick      (sec_tick),
        .ev_first  (ev_first),
        .ev_second (ev_second)
    );

    belt_ctrl_fsm u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .pulses   (pulses),
        .alarming (alarm_active)
    );

    assign timer_start = pulses.start;
    assign alarm_on    = pulses.alarm_on;
    assign alarm_off   = pulses.alarm_off;
endmodule

// File: rtl/belt_reminder_chk.sv
module belt_reminder_chk #(
    parameter int unsigned FIRST_TICKS  = 5,
    parameter int unsigned SECOND_TICKS = 10
) (
    input logic clk,
    input logic rst,
    input logic key_on,
    input logic key_off,
    input logic belt_on,
    input logic sec_tick,
    input logic timer_start,
    input logic alarm_on,
    input logic alarm_off,
    input logic alarm_active
);
    localparam int unsigned SPAN  = SECOND_TICKS - FIRST_TICKS;
    localparam int unsigned SPAN_W = $clog2(SPAN + 2);

    logic [SPAN_W-1:0] alarm_ticks_q;

    always_ff @(posedge clk) begin
        if (rst || !alarm_active) begin
            alarm_ticks_q <= '0;
        end else if (sec_tick && alarm_ticks_q != '1) begin
            alarm_ticks_q <= alarm_ticks_q + 1'b1;
        end
    end

    // R2
    start_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        timer_start |-> (key_on && !alarm_active));

    // R4
    alarm_on_enters_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_on |=> alarm_active);

    // R5
    alarm_off_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_off |=> !alarm_active);

    // R5
    alarm_exit_event_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_active && (key_off || belt_on)) |-> alarm_off);

    // R8
    quiet_exit_wins_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_on |-> (!key_off && !belt_on && sec_tick));

    // R9
    alarm_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_active) |-> $past(alarm_on));

    // R9
    alarm_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_active) |-> $past(alarm_off));

    // R6
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({timer_start, alarm_on, alarm_off}));

    // R10
    alarm_length_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_ticks_q <= SPAN_W'(SPAN));
endmodule

bind belt_reminder_top belt_reminder_chk #(
    .FIRST_TICKS  (FIRST_TICKS),
    .SECOND_TICKS (SECOND_TICKS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .key_on       (key_on),
    .key_off      (key_off),
    .belt_on      (belt_on),
    .sec_tick     (sec_tick),
    .timer_start  (timer_start),
    .alarm_on     (alarm_on),
    .alarm_off    (alarm_off),
    .alarm_active (alarm_active)
);

// File: tb/sim_belt_reminder_top.sv
module sim_belt_reminder_top;
    localparam int CLK_PERIOD = 10;
    localparam int N1 = 5;
    localparam int N2 = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_on = 1'b0, key_off = 1'b0, belt_on = 1'b0, sec_tick = 1'b0;
    logic timer_start, alarm_on, alarm_off, alarm_active;

    int checks = 0;
    int fails  = 0;

    // reference model: 0 idle, 1 wait, 2 alarm
    int  m_st  = 0;
    int  m_cnt = 0;
    bit  m_run = 0;
    bit  e_start, e_on, e_off;

    always #(CLK_PERIOD/2) clk = ~clk;

    belt_reminder_top u0 (
        .clk(clk), .rst(rst), .key_on(key_on), .key_off(key_off),
        .belt_on(belt_on), .sec_tick(sec_tick), .timer_start(timer_start),
        .alarm_on(alarm_on), .alarm_off(alarm_off), .alarm_active(alarm_active)
    );

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic bit ev_first_f(bit tk);
        return tk && m_run && (m_cnt == N1 - 1) && !e_start;
    endfunction

    function automatic bit ev_second_f(bit tk);
        return tk && m_run && (m_cnt == N2 - 1) && !e_start;
    endfunction

    // expected pulses from model state and inputs
    task automatic expect_outs(bit ko, bit kf, bit bt, bit tk);
        e_start = (m_st == 0) && ko;
        e_on    = (m_st == 1) && !kf && !bt && ev_first_f(tk);
        e_off   = (m_st == 2) && (kf || bt || ev_second_f(tk));
    endtask

    task automatic model_step(bit ko, bit kf, bit bt, bit tk);
        bit f2;
        f2 = ev_second_f(tk);
        if (m_st == 0 && ko) m_st = 1;
        else if (m_st == 1 && (kf || bt)) m_st = 0;
        else if (m_st == 1 && ev_first_f(tk)) m_st = 2;
        else if (m_st == 2 && (kf || bt || f2)) m_st = 0;
        if (e_start) begin
            m_run = 1; m_cnt = 0;
        end else if (tk && m_run) begin
            if (f2) begin m_run = 0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
    endtask

    // one cycle: drive after negedge, compare, advance model at posedge
    task automatic cyc(bit ko, bit kf, bit bt, bit tk);
        key_on = ko; key_off = kf; belt_on = bt; sec_tick = tk;
        #1;
        expect_outs(ko, kf, bt, tk);
        check("R9 alarm_active", alarm_active, m_st == 2);
        check("R2 timer_start", timer_start, e_start);
        check("R4 alarm_on", alarm_on, e_on);
        check("R5 alarm_off", alarm_off, e_off);
        @(posedge clk);
        model_step(ko, kf, bt, tk);
        @(negedge clk);
        key_on = 0; key_off = 0; belt_on = 0; sec_tick = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 timer_start", timer_start, 1'b0);
        check("R1 alarm_on", alarm_on, 1'b0);
        check("R1 alarm_off", alarm_off, 1'b0);
        check("R1 alarm_active", alarm_active, 1'b0);
        rst = 1'b0;
        #1;
        check("R1 alarm_active after reset", alarm_active, 1'b0);

        // R7: tick with start is not counted; 5th tick after raises alarm (R4)
        cyc(1, 0, 0, 1);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0, 1);
            cyc(0, 0, 0, 0);
        end
        check("R7 no alarm after four counted ticks", alarm_active, 1'b0);
        key_on = 1'b1; // R2: key-on in wait does nothing
        sec_tick = 1'b1;
        #1;
        check("R4 fifth tick alarm_on", alarm_on, 1'b1);
        check("R2 key_on ignored in wait", timer_start, 1'b0);
        key_on = 1'b0; sec_tick = 1'b0;
        cyc(0, 0, 0, 1);
        // now alarming; R10: full alarm lasts five ticks
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
        check("R10 still alarming after four alarm ticks", alarm_active, 1'b1);
        sec_tick = 1'b1;
        #1;
        check("R5 R10 tenth tick alarm_off", alarm_off, 1'b1);
        sec_tick = 1'b0;
        cyc(0, 0, 0, 1);
        // R7: counter idle, further ticks raise nothing
        for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1);
        check("R7 idle counter no alarm", alarm_active, 1'b0);

        // R8: key-off with fifth tick
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
        key_off = 1'b1; sec_tick = 1'b1;
        #1;
        check("R8 key_off beats fifth tick", alarm_on, 1'b0);
        key_off = 1'b0; sec_tick = 1'b0;
        cyc(0, 1, 0, 1);
        check("R8 idle after key_off", alarm_active, 1'b0);

        // R3: belt in wait returns quietly, then a restart counts from zero
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 0);
        check("R3 belt in wait no alarm", alarm_active, 1'b0);
        cyc(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
        check("R7 restart counts from zero", alarm_active, 1'b0);
        cyc(0, 0, 0, 1);
        check("R4 alarm after restart", alarm_active, 1'b1);
        // R5: belt ends alarm; R6: no events keeps state
        cyc(0, 0, 0, 0);
        check("R6 alarm holds with no events", alarm_active, 1'b1);
        cyc(0, 0, 1, 0);
        check("R5 belt ends alarm", alarm_active, 1'b0);
        cyc(0, 0, 0, 0);
        check("R6 idle holds", alarm_active, 1'b0);

        // random traffic against reference model
        for (int i = 0; i < 4000; i++) begin
            bit ko, kf, bt, tk;
            ko = ($urandom_range(0, 15) == 0);
            kf = ($urandom_range(0, 39) == 0);
            bt = ($urandom_range(0, 39) == 0);
            tk = ($urandom_range(0, 2) == 0);
            cyc(ko, kf, bt, tk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule